// File: doc/BRIEF.md
# Start/Stop Serial Character Receiver

This block recovers characters from an asynchronous serial line framed by a start bit and a stop bit. It runs on the system clock and advances only on a sampling enable, which is either sixteen times the bit rate or equal to it. The character length, parity mode and clock factor are set through configuration inputs. A compare character is also configured, and each received character is checked against it.

Every character is presented together with its parity, framing and overrun flags, a break marker and a compare-match flag. It stays on the outputs until the consumer acknowledges it. A line held low is reported as a single break character with a one-cycle start pulse. When the line first returns high, a separate one-cycle end pulse follows. A start bit that is too short to reach its centre sample is discarded without producing a character.

Top module: `async_rx`

## Requirements
- R1: `cfg_len` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Bits arrive least significant first. `char_data` holds the character right-aligned, and every bit above the length reads zero.
- R2: When `cfg_x16`=1, a start is seen on the first enable with the line low. The start bit is re-sampled 8 enables later, and each following bit is sampled 16 enables after the one before it. The character appears on the clock edge of the stop-bit sample.
- R3: When `cfg_x16`=0, every enable samples one bit. The enable that first sees the line low counts as the start bit.
- R4: In 16x mode, a start bit that reads high at its centre sample is dropped. No character is delivered, and the receiver hunts for a new start.
- R5: `cfg_par` encodes 0=none, 1=even, 2=odd, 3=forced. For even parity the expected bit is the XOR of the data bits, and for odd parity it is the inverse of that XOR. For forced parity the expected bit equals `cfg_par_fixed`. `err_par` is set when the received parity bit differs from the expected bit, and it stays 0 when `cfg_par` is none.
- R6: `err_frm` is set when the stop bit is sampled low.
- R7: A break is a character whose data bits are all zero, whose parity bit (if present) is zero, and whose stop bit is zero. It is delivered once, with `is_break`=1, `err_frm`=1, `err_par`=0 and `cmp_match`=0, and `brk_start` pulses in the same cycle that the character appears.
- R8: After a break, no further characters are taken while the line stays low. `brk_end` pulses for one cycle after the first enable that sees the line high, and the receiver then returns to hunting.
- R9: `err_ovr` is set on a new character when the previous one was still valid and `rd_ack` was not high on the completion edge. An acknowledge on that same edge leaves `err_ovr` clear.
- R10: `cmp_match` is set when the received character equals `cfg_cmp` restricted to the low character-length bits.
- R11: After reset, `char_valid`, `brk_start` and `brk_end` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | Sampling enable (16x or 1x bit rate) |
| rxd_in | input | 1 | Serial data line, idle high |
| cfg_x16 | input | 1 | 1: 16x clock factor, 0: 1x |
| cfg_len | input | 2 | Character length code (5 + code bits) |
| cfg_par | input | 2 | Parity mode: none, even, odd, forced |
| cfg_par_fixed | input | 1 | Expected parity bit value in forced mode |
| cfg_cmp | input | 8 | Compare character |
| rd_ack | input | 1 | Consumer takes the current character |
| char_valid | output | 1 | A character is waiting |
| char_data | output | 8 | Received character, right-aligned |
| err_par | output | 1 | Parity error for this character |
| err_frm | output | 1 | Framing error for this character |
| err_ovr | output | 1 | Previous character was overwritten |
| is_break | output | 1 | This character is a break |
| cmp_match | output | 1 | Character equals the compare value |
| brk_start | output | 1 | One-cycle pulse: break begins |
| brk_end | output | 1 | One-cycle pulse: line returned high after break |

## Verification
The consumer's acknowledge and the completion of the next character can fall on the same clock edge. That edge is where the receiver decides whether the waiting character was overwritten. The bench holds off its acknowledges, lets a first character wait, and then raises `rd_ack` exactly on the enable that samples the second character's stop bit. The second character must then arrive with `err_ovr` clear. A matching run without that acknowledge must arrive with `err_ovr` set.

// File: rtl/async_rx.sv
module async_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       samp_en,
  input  logic       rxd_in,
  input  logic       cfg_x16,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_par,
  input  logic       cfg_par_fixed,
  input  logic [7:0] cfg_cmp,
  input  logic       rd_ack,
  output logic       char_valid,
  output logic [7:0] char_data,
  output logic       err_par,
  output logic       err_frm,
  output logic       err_ovr,
  output logic       is_break,
  output logic       cmp_match,
  output logic       brk_start,
  output logic       brk_end
);
  localparam int PW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;
  st_t st;

  logic [PW-1:0] ph;
  logic [2:0]    bcnt;
  logic [7:0]    shr;
  logic          pacc, pbit;

  wire [3:0] nbits   = 4'd5 + {2'b00, cfg_len};
  wire [7:0] mask    = 8'hFF >> (4'd8 - nbits);
  wire [7:0] aligned = shr >> (4'd8 - nbits);
  wire       tick    = samp_en && (!cfg_x16 || ph == PW'(OVS - 1));
  wire       mid     = samp_en && ph == PW'(HALF - 1);
  wire       last    = {1'b0, bcnt} == nbits - 4'd1;
  wire       no_par  = cfg_par == 2'd0;
  wire       exp_par = (cfg_par == 2'd3) ? cfg_par_fixed :
                       (cfg_par == 2'd2) ? ~pacc : pacc;
  wire       brk_cond = shr == 8'd0 && !rxd_in && (no_par || !pbit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; bcnt <= '0; shr <= '0; pacc <= 1'b0; pbit <= 1'b0;
      char_valid <= 1'b0; char_data <= '0; err_par <= 1'b0; err_frm <= 1'b0;
      err_ovr <= 1'b0; is_break <= 1'b0; cmp_match <= 1'b0;
      brk_start <= 1'b0; brk_end <= 1'b0;
    end else begin
      brk_start <= 1'b0;
      brk_end   <= 1'b0;
      if (rd_ack) char_valid <= 1'b0;
      if (samp_en && st != S_IDLE && st != S_START && st != S_BRK)
        ph <= tick ? '0 : ph + 1'b1;
      case (st)
        S_IDLE:
          if (samp_en && !rxd_in) begin
            ph <= '0; bcnt <= '0; shr <= '0; pacc <= 1'b0; pbit <= 1'b0;
            st <= cfg_x16 ? S_START : S_DATA;
          end
        S_START:
          if (mid) begin
            ph <= '0;
            st <= rxd_in ? S_IDLE : S_DATA;
          end else if (samp_en) ph <= ph + 1'b1;
        S_DATA:
          if (tick) begin
            shr  <= {rxd_in, shr[7:1]};
            pacc <= pacc ^ rxd_in;
            bcnt <= bcnt + 3'd1;
            if (last) st <= no_par ? S_STOP : S_PAR;
          end
        S_PAR:
          if (tick) begin
            pbit <= rxd_in;
            st   <= S_STOP;
          end
        S_STOP:
          if (tick) begin
            char_valid <= 1'b1;
            char_data  <= aligned;
            err_ovr    <= char_valid && !rd_ack;
            err_frm    <= !rxd_in;
            is_break   <= brk_cond;
            err_par    <= !brk_cond && !no_par && (pbit != exp_par);
            cmp_match  <= !brk_cond && aligned == (cfg_cmp & mask);
            brk_start  <= brk_cond;
            st         <= brk_cond ? S_BRK : S_IDLE;
          end
        S_BRK:
          if (samp_en && rxd_in) begin
            brk_end <= 1'b1;
            st      <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  len_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(char_valid) |-> (char_data & ~(8'hFF >> (4'd3 - {2'b00, cfg_len}))) == 8'd0);
  // R2
  deliver_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(char_valid) |-> $past(samp_en));
  // R7
  brk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |-> char_valid && is_break && err_frm && char_data == 8'd0 && !cmp_match);
  // R8
  brk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_end |-> $past(rxd_in) && $past(samp_en) && !brk_start);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(char_valid) |-> !err_ovr);
endmodule

// File: tb/test_async_rx.sv
module test_async_rx;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, samp_en = 1'b0, rxd_in = 1'b1;
  logic cfg_x16 = 1'b1, cfg_par_fixed = 1'b0;
  logic [1:0] cfg_len = 2'd3, cfg_par = 2'd0;
  logic [7:0] cfg_cmp = 8'h00;
  logic mon_ack = 1'b0, drv_ack = 1'b0, rd_ack;
  logic char_valid, err_par, err_frm, err_ovr, is_break, cmp_match, brk_start, brk_end;
  logic [7:0] char_data;
  assign rd_ack = mon_ack | drv_ack;

  async_rx i_async_rx (.clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rxd_in(rxd_in),
    .cfg_x16(cfg_x16), .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_par_fixed(cfg_par_fixed),
    .cfg_cmp(cfg_cmp), .rd_ack(rd_ack), .char_valid(char_valid), .char_data(char_data),
    .err_par(err_par), .err_frm(err_frm), .err_ovr(err_ovr), .is_break(is_break),
    .cmp_match(cmp_match), .brk_start(brk_start), .brk_end(brk_end));

  always #(CLK_P/2) clk = ~clk;

  typedef struct packed { logic [7:0] d; logic pe, fe, oe, brk, m; } exp_t;
  exp_t q[$];
  string tq[$];
  int checks = 0, fails = 0, nbrk_end = 0;
  bit auto_ack = 1'b1, chk_time = 1'b0, ack_at_stop = 1'b0, exp_ovr = 1'b0, done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // monitor: pops expected characters as the receiver presents them
  always @(negedge clk) begin
    if (rst_n && brk_end) nbrk_end++;
    if (mon_ack) mon_ack = 1'b0;
    else if (rst_n && char_valid && auto_ack) begin
      if (q.size() == 0) begin
        check(1'b0, "R4 unexpected character", {8'h0, char_data}, 16'h0);
      end else begin
        exp_t e; string t; exp_t g;
        e = q.pop_front(); t = tq.pop_front();
        g = {char_data, err_par, err_frm, err_ovr, is_break, cmp_match};
        check(g == e && brk_start == e.brk, t, {2'b0, g, brk_start}, {2'b0, e, e.brk});
      end
      mon_ack = 1'b1;
    end
  end

  task automatic pulse(input bit stop_samp);
    @(negedge clk);
    samp_en = 1'b1;
    if (stop_samp && ack_at_stop) drv_ack = 1'b1;
    if (stop_samp && chk_time) check(char_valid == 1'b0, "R2 early delivery", {15'h0, char_valid}, 16'h0);
    @(negedge clk);
    samp_en = 1'b0;
    drv_ack = 1'b0;
    if (stop_samp && chk_time) check(char_valid == 1'b1, "R2 delivery edge", {15'h0, char_valid}, 16'h1);
  endtask

  task automatic put_bit(input logic b, input bit is_stop);
    int n = cfg_x16 ? 16 : 1;
    int s = cfg_x16 ? 8 : 0;
    rxd_in = b;
    for (int i = 0; i < n; i++) pulse(is_stop && i == s);
  endtask

  task automatic idle(input int n);
    rxd_in = 1'b1;
    for (int i = 0; i < n; i++) pulse(1'b0);
  endtask

  task automatic send_char(input logic [7:0] d, input bit badpar, input logic stopv,
                           input bit push, input string tag);
    int nb = 5 + int'(cfg_len);
    logic [7:0] m = 8'hFF >> (8 - nb);
    logic [7:0] dm = d & m;
    logic ep, pb; exp_t e; bit brk;
    ep = (cfg_par == 2'd3) ? cfg_par_fixed : (cfg_par == 2'd2) ? ~(^dm) : ^dm;
    pb = ep ^ badpar;
    brk = dm == 8'h0 && stopv == 1'b0 && (cfg_par == 2'd0 || pb == 1'b0);
    e.d = dm; e.fe = !stopv; e.oe = exp_ovr; e.brk = brk;
    e.pe = !brk && cfg_par != 2'd0 && badpar;
    e.m = !brk && dm == (cfg_cmp & m);
    if (push) begin q.push_back(e); tq.push_back(tag); end
    put_bit(1'b0, 1'b0);
    for (int i = 0; i < nb; i++) put_bit(d[i], 1'b0);
    if (cfg_par != 2'd0) put_bit(pb, 1'b0);
    put_bit(stopv, 1'b1);
  endtask

  task automatic drain(input string tag);
    repeat (6) @(negedge clk);
    check(q.size() == 0, tag, 16'(q.size()), 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(char_valid == 0 && brk_start == 0 && brk_end == 0, "R11 reset",
          {13'h0, char_valid, brk_start, brk_end}, 16'h0);
    rst_n = 1'b1;
    idle(4);
    // R1 R2 8-bit, no parity, 16x with delivery timing
    chk_time = 1'b1;
    send_char(8'hA5, 0, 1, 1, "R1 8-bit A5"); idle(16);
    send_char(8'h3C, 0, 1, 1, "R2 8-bit 3C"); idle(16);
    chk_time = 1'b0;
    // R5 parity modes
    cfg_len = 2'd0; cfg_par = 2'd1;
    send_char(8'hF5, 0, 1, 1, "R5 5-bit even"); idle(16);
    send_char(8'h13, 1, 1, 1, "R5 even parity error"); idle(16);
    cfg_len = 2'd1; cfg_par = 2'd2;
    send_char(8'h2D, 0, 1, 1, "R5 6-bit odd"); idle(16);
    send_char(8'h01, 1, 1, 1, "R5 odd parity error"); idle(16);
    cfg_len = 2'd2; cfg_par = 2'd3; cfg_par_fixed = 1'b1;
    send_char(8'h55, 0, 1, 1, "R5 forced one"); idle(16);
    cfg_par_fixed = 1'b0;
    send_char(8'h7F, 1, 1, 1, "R5 forced zero mismatch"); idle(16);
    // R6 framing
    cfg_len = 2'd3; cfg_par = 2'd0;
    send_char(8'h81, 0, 0, 1, "R6 framing error"); idle(16);
    drain("R6 queue");
    // R10 compare, masked to length
    cfg_cmp = 8'hE6; cfg_len = 2'd1;
    send_char(8'h26, 0, 1, 1, "R10 6-bit match"); idle(16);
    send_char(8'h27, 0, 1, 1, "R10 no match"); idle(16);
    cfg_len = 2'd3;
    // R4 false start
    rxd_in = 1'b0; repeat (5) pulse(1'b0);
    idle(24);
    drain("R4 false start");
    send_char(8'h5A, 0, 1, 1, "R4 recovery"); idle(16);
    // R7 R8 break
    begin
      int b0 = nbrk_end;
      send_char(8'h00, 0, 0, 1, "R7 break char");
      rxd_in = 1'b0; repeat (40) pulse(1'b0);
      check(nbrk_end == b0, "R8 no early end", 16'(nbrk_end - b0), 16'h0);
      drain("R7 single break char");
      idle(4);
      check(nbrk_end == b0 + 1, "R8 end pulse", 16'(nbrk_end - b0), 16'h1);
      idle(12);
      send_char(8'hC3, 0, 1, 1, "R8 back to hunt"); idle(16);
    end
    // R3 1x mode
    cfg_x16 = 1'b0;
    send_char(8'h96, 0, 1, 1, "R3 1x 96"); idle(3);
    cfg_par = 2'd1; cfg_len = 2'd2;
    send_char(8'h4B, 0, 1, 1, "R3 1x even"); idle(3);
    cfg_par = 2'd0; cfg_len = 2'd3;
    // R9 overrun without acknowledge
    auto_ack = 1'b0;
    send_char(8'h11, 0, 1, 0, ""); idle(3);
    exp_ovr = 1'b1;
    send_char(8'h22, 0, 1, 1, "R9 overrun"); idle(3);
    exp_ovr = 1'b0;
    auto_ack = 1'b1; drain("R9 overrun drain");
    // R9 acknowledge on the completion edge
    auto_ack = 1'b0;
    send_char(8'h33, 0, 1, 0, ""); idle(3);
    ack_at_stop = 1'b1;
    send_char(8'h44, 0, 1, 1, "R9 ack same edge");
    ack_at_stop = 1'b0;
    idle(3);
    auto_ack = 1'b1; drain("R9 same edge drain");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule